// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Memory Device Model

This block is a clocked, synthesizable model of a 2048 x 8 electrically erasable memory with a parallel interface. It has an 11-bit address, separate data-in and data-out buses with a data-out enable, and three active-low controls: chip select, output gate and write strobe. An open-drain busy indication is given as a pull-low request. All inputs are sampled on the rising clock edge, so the edges of the write strobe are seen as changes between consecutive clock samples.

The write strobe first passes a pulse-width filter. A low pulse that is long enough starts a self-timed write. The location is taken when the strobe falls, and the data, chip select and output gate are taken when it rises. The write then erases the target byte to all ones and programs it, and busy is held throughout. While busy, a read of the target returns a polling byte that carries the inverse of the new bit 7. Two digital flags stand in for the high-voltage pins. One maps the top 32 addresses onto a separate identification row. The other turns a qualified strobe into a clear of the whole main array. A supply-good flag gates the start of every programming operation.

Top module: `pnvm_device`

## Requirements
- R1: With cs_n=0, og_n=0 and wstb_n=1, dout_en is 1 and dout equals the stored byte at the current location in the same cycle, with no clock edge in between.
- R2: dout_en is 0 whenever cs_n=1, og_n=1 or wstb_n=0.
- R3: The location (address and row select) is captured at the first clock sample of wstb_n low after a high sample. The data, cs_n, og_n and hv_clear are captured at the first high sample after that. A byte write starts only if cs_n=0 and og_n=1 in that rise sample.
- R4: A wstb_n low pulse that lasts fewer than FILT_CYC clock samples starts nothing. A pulse of FILT_CYC or more samples is accepted.
- R5: A byte write drives rb_pull_low=1 from the clock after the rise sample for exactly PROG_CYC+1 cycles. After that the new byte is stored.
- R6: Each byte write erases the target to 8'hFF before programming, which clears bits only. The stored result therefore equals the new data whatever the old value was.
- R7: While a byte write is busy, a read of its target location returns {~d[7], 7'b0}, where d is the byte being written. Reads of any other location return the stored data.
- R8: Strobe activity while busy is ignored. It neither extends the current operation nor starts or queues another one.
- R9: When hv_idrow=1 and addr[10:5]=6'b111111, reads and writes use a separate 32-byte identification row indexed by addr[4:0]. The main bytes at 0x7E0-0x7FF are not touched. Every other address reaches the main array.
- R10: A qualified pulse with cs_n=0 and hv_clear=1 in the rise sample sets all 2048 main bytes to 8'hFF. It clears one byte per cycle and holds rb_pull_low for 2048 cycles. The identification row is kept.
- R11: With supply_ok=0 in the rise sample, no write or clear starts and rb_pull_low stays 0.
- R12: During and after reset, rb_pull_low is 0. Reset does not alter the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| og_n | input | 1 | Output gate, active low |
| wstb_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| hv_idrow | input | 1 | Stand-in for the high voltage on address bit 9: selects the identification row |
| hv_clear | input | 1 | Stand-in for the high voltage on the output gate: requests an array clear |
| supply_ok | input | 1 | Supply above the programming threshold |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Drive enable for dout (0 means high impedance) |
| rb_pull_low | output | 1 | Open-drain busy: 1 pulls the ready line low |

## Verification
The bench clears the array, then writes a computed pattern to every address and reads all of it back. It probes the filter at FILT_CYC-1 and FILT_CYC samples, where an off-by-one filter would accept a glitch or reject a valid pulse. It moves the address and the data during a pulse, which exposes a design that latches on the wrong edge: the byte would land at the late address or take the early data. It also writes a byte whose bits conflict with the old value, which exposes a missing erase (the result would be the AND of old and new). It reads the target during busy, where a wrong polling path would return true or stale data. Strobes while busy, supply loss, inhibit levels and identification-row aliasing are each checked for stray writes, and a second clear is checked to leave the identification row intact.

// File: rtl/pnvm_pkg.sv
package pnvm_pkg;

    localparam int PNVM_ADDR_W = 11;
    localparam int PNVM_DATA_W = 8;
    localparam int PNVM_ID_AW  = 5;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_PROG  = 2'd2,
        PH_CLEAR = 2'd3
    } pnvm_phase_e;

    typedef enum logic {
        CELL_ERASE = 1'b0,
        CELL_PROG  = 1'b1
    } cell_op_e;

    typedef struct packed {
        logic                   id_row;
        logic [PNVM_ADDR_W-1:0] addr;
    } pnvm_loc_t;

    // Identification row is reached only through the top address window.
    function automatic logic in_id_window(input logic hv, input logic [PNVM_ADDR_W-1:0] a);
        return hv && (&a[PNVM_ADDR_W-1:PNVM_ID_AW]);
    endfunction

    function automatic logic [PNVM_DATA_W-1:0] poll_byte(input logic [PNVM_DATA_W-1:0] d);
        return {~d[PNVM_DATA_W-1], {(PNVM_DATA_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/pnvm_wstb_qual.sv
module pnvm_wstb_qual
    import pnvm_pkg::*;
#(
    parameter int FILT_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hold,
    input  logic                   wstb_n,
    input  logic                   hv_idrow,
    input  logic [PNVM_ADDR_W-1:0] addr,
    output logic                   fire,
    output pnvm_loc_t              loc
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          wstb_q;
    logic          armed;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wstb_q  <= 1'b1;
            armed   <= 1'b0;
            low_cnt <= '0;
            loc     <= '0;
        end else begin
            wstb_q <= wstb_n;
            if (wstb_q && !wstb_n) begin
                // falling sample: location is taken here, unless busy
                armed   <= !hold;
                low_cnt <= CW'(1);
                if (!hold) begin
                    loc <= '{id_row: in_id_window(hv_idrow, addr), addr: addr};
                end
            end else if (!wstb_n && low_cnt != CW'(FILT_CYC)) begin
                low_cnt <= low_cnt + CW'(1);
            end else if (!wstb_q && wstb_n) begin
                armed <= 1'b0;
            end
        end
    end

    assign fire = !wstb_q && wstb_n && armed && !hold && (low_cnt >= CW'(FILT_CYC));

endmodule

// File: rtl/pnvm_prog_seq.sv
module pnvm_prog_seq
    import pnvm_pkg::*;
#(
    parameter int PROG_CYC = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fire,
    input  pnvm_loc_t              req_loc,
    input  logic [PNVM_DATA_W-1:0] req_data,
    input  logic                   req_cs_n,
    input  logic                   req_og_n,
    input  logic                   req_clear,
    input  logic                   supply_ok,
    output logic                   busy,
    output logic                   poll_active,
    output pnvm_loc_t              poll_loc,
    output logic [PNVM_DATA_W-1:0] poll_data,
    output logic                   wr_en,
    output cell_op_e               wr_op,
    output pnvm_loc_t              wr_loc,
    output logic [PNVM_DATA_W-1:0] wr_data
);
    localparam int CNT_W = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;

    pnvm_phase_e              phase;
    logic [CNT_W-1:0]         cnt;
    logic [PNVM_ADDR_W-1:0]   sweep;
    pnvm_loc_t                cur_loc;
    logic [PNVM_DATA_W-1:0]   cur_data;

    logic start_ok, start_clr, start_wr, prog_last;
    assign start_ok  = fire && supply_ok && !req_cs_n;
    assign start_clr = start_ok && req_clear;
    assign start_wr  = start_ok && !req_clear && req_og_n;
    assign prog_last = (cnt == CNT_W'(PROG_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            sweep    <= '0;
            cur_loc  <= '0;
            cur_data <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start_clr) begin
                        phase <= PH_CLEAR;
                        sweep <= '0;
                    end else if (start_wr) begin
                        phase    <= PH_ERASE;
                        cur_loc  <= req_loc;
                        cur_data <= req_data;
                    end
                end
                PH_ERASE: begin
                    phase <= PH_PROG;
                    cnt   <= '0;
                end
                PH_PROG: begin
                    if (prog_last) phase <= PH_IDLE;
                    else           cnt   <= cnt + CNT_W'(1);
                end
                PH_CLEAR: begin
                    if (&sweep) phase <= PH_IDLE;
                    else        sweep <= sweep + PNVM_ADDR_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_op   = CELL_ERASE;
        wr_loc  = cur_loc;
        wr_data = cur_data;
        unique case (phase)
            PH_ERASE: wr_en = 1'b1;
            PH_PROG: begin
                wr_en = prog_last;
                wr_op = CELL_PROG;
            end
            PH_CLEAR: begin
                wr_en  = 1'b1;
                wr_loc = '{id_row: 1'b0, addr: sweep};
            end
            default: wr_en = 1'b0;
        endcase
    end

    assign busy        = (phase != PH_IDLE);
    assign poll_active = (phase == PH_ERASE) || (phase == PH_PROG);
    assign poll_loc    = cur_loc;
    assign poll_data   = poll_byte(cur_data);

endmodule

// File: rtl/pnvm_cell_array.sv
module pnvm_cell_array
    import pnvm_pkg::*;
#(
    parameter int MAIN_DEPTH = 1 << PNVM_ADDR_W,
    parameter int ID_DEPTH   = 1 << PNVM_ID_AW
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  cell_op_e               wr_op,
    input  pnvm_loc_t              wr_loc,
    input  logic [PNVM_DATA_W-1:0] wr_data,
    input  pnvm_loc_t              rd_loc,
    output logic [PNVM_DATA_W-1:0] rd_data
);
    logic [PNVM_DATA_W-1:0] main_cells [MAIN_DEPTH];
    logic [PNVM_DATA_W-1:0] id_cells   [ID_DEPTH];

    logic [PNVM_DATA_W-1:0] old_byte;
    logic [PNVM_DATA_W-1:0] new_byte;

    assign old_byte = wr_loc.id_row ? id_cells[wr_loc.addr[PNVM_ID_AW-1:0]]
                                    : main_cells[wr_loc.addr];
    // programming can only clear bits; erase returns the byte to all ones
    assign new_byte = (wr_op == CELL_ERASE) ? '1 : (old_byte & wr_data);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_loc.id_row) id_cells[wr_loc.addr[PNVM_ID_AW-1:0]] <= new_byte;
            else               main_cells[wr_loc.addr]                <= new_byte;
        end
    end

    assign rd_data = rd_loc.id_row ? id_cells[rd_loc.addr[PNVM_ID_AW-1:0]]
                                   : main_cells[rd_loc.addr];

endmodule

// File: rtl/pnvm_device.sv
module pnvm_device
    import pnvm_pkg::*;
#(
    parameter int FILT_CYC = 4,
    parameter int PROG_CYC = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   og_n,
    input  logic                   wstb_n,
    input  logic [PNVM_ADDR_W-1:0] addr,
    input  logic [PNVM_DATA_W-1:0] din,
    input  logic                   hv_idrow,
    input  logic                   hv_clear,
    input  logic                   supply_ok,
    output logic [PNVM_DATA_W-1:0] dout,
    output logic                   dout_en,
    output logic                   rb_pull_low
);
    localparam int ADDR_W = PNVM_ADDR_W;

    logic                   busy;
    logic                   fire;
    pnvm_loc_t              cap_loc;
    logic                   poll_active;
    pnvm_loc_t              poll_loc;
    logic [PNVM_DATA_W-1:0] poll_data;
    logic                   wr_en;
    cell_op_e               wr_op;
    pnvm_loc_t              wr_loc;
    logic [PNVM_DATA_W-1:0] wr_data;
    pnvm_loc_t              rd_loc;
    logic [PNVM_DATA_W-1:0] rd_data;

    pnvm_wstb_qual #(.FILT_CYC(FILT_CYC)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .hold     (busy),
        .wstb_n   (wstb_n),
        .hv_idrow (hv_idrow),
        .addr     (addr),
        .fire     (fire),
        .loc      (cap_loc)
    );

    pnvm_prog_seq #(.PROG_CYC(PROG_CYC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .req_loc     (cap_loc),
        .req_data    (din),
        .req_cs_n    (cs_n),
        .req_og_n    (og_n),
        .req_clear   (hv_clear),
        .supply_ok   (supply_ok),
        .busy        (busy),
        .poll_active (poll_active),
        .poll_loc    (poll_loc),
        .poll_data   (poll_data),
        .wr_en       (wr_en),
        .wr_op       (wr_op),
        .wr_loc      (wr_loc),
        .wr_data     (wr_data)
    );

    pnvm_cell_array u_cells (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_op   (wr_op),
        .wr_loc  (wr_loc),
        .wr_data (wr_data),
        .rd_loc  (rd_loc),
        .rd_data (rd_data)
    );

    assign rd_loc      = '{id_row: in_id_window(hv_idrow, addr), addr: addr};
    assign dout_en     = !cs_n && !og_n && wstb_n;
    assign dout        = (poll_active && rd_loc == poll_loc) ? poll_data : rd_data;
    assign rb_pull_low = busy;

endmodule

// File: rtl/pnvm_checker.sv
module pnvm_checker #(
    parameter int PROG_CYC = 12,
    parameter int ADDR_W   = 11
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic og_n,
    input logic wstb_n,
    input logic hv_clear,
    input logic supply_ok,
    input logic dout_en,
    input logic rb_pull_low,
    input logic poll_active
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !rb_pull_low) run_len <= '0;
        else                     run_len <= run_len + 32'd1;
    end

    assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !dout_en);

    assert_start_qual_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rb_pull_low) |-> ($past(wstb_n) && !$past(wstb_n, 2) && !$past(cs_n)
                                && ($past(og_n) || $past(hv_clear))));

    assert_write_len_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(rb_pull_low) && $past(poll_active)) |-> (run_len == 32'(PROG_CYC + 1)));

    assert_clear_len_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(rb_pull_low) && !$past(poll_active)) |-> (run_len == 32'(1 << ADDR_W)));

    assert_supply_gate_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(rb_pull_low) |-> $past(supply_ok));

endmodule

bind pnvm_device pnvm_checker #(.PROG_CYC(PROG_CYC), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .og_n        (og_n),
    .wstb_n      (wstb_n),
    .hv_clear    (hv_clear),
    .supply_ok   (supply_ok),
    .dout_en     (dout_en),
    .rb_pull_low (rb_pull_low),
    .poll_active (poll_active)
);

// File: tb/test_pnvm_device.sv
module test_pnvm_device;

    localparam int FILT = 4;
    localparam int PC   = 12;
    localparam int NMAIN = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, og_n = 1'b1, wstb_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic        hv_idrow = 1'b0, hv_clear = 1'b0, supply_ok = 1'b1;
    logic [7:0]  dout;
    logic        dout_en;
    logic        rb_pull_low;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_main [NMAIN];
    logic [7:0] exp_id   [32];

    always #4 clk = ~clk;

    pnvm_device #(.FILT_CYC(FILT), .PROG_CYC(PC)) i_pnvm_device (
        .clk(clk), .rst(rst), .cs_n(cs_n), .og_n(og_n), .wstb_n(wstb_n),
        .addr(addr), .din(din), .hv_idrow(hv_idrow), .hv_clear(hv_clear),
        .supply_ok(supply_ok), .dout(dout), .dout_en(dout_en),
        .rb_pull_low(rb_pull_low)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) ^ (a >> 8));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [10:0] a_fall, input logic [10:0] a_rise,
                         input logic [7:0] d, input int low, input logic ce,
                         input logic oe, input logic hvc, input logic hva);
        @(negedge clk);
        cs_n = ce; og_n = oe; hv_clear = hvc; hv_idrow = hva;
        addr = a_fall; din = ~d; wstb_n = 1'b0;
        repeat (low) begin
            @(negedge clk);
            addr = a_rise;
        end
        din = d; wstb_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; og_n = 1'b1; hv_clear = 1'b0; hv_idrow = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (rb_pull_low && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [10:0] a, input logic hva, output logic [7:0] v, output logic en);
        cs_n = 1'b0; og_n = 1'b0; wstb_n = 1'b1; hv_idrow = hva; addr = a;
        #1;
        v = dout; en = dout_en;
        cs_n = 1'b1; og_n = 1'b1; hv_idrow = 1'b0;
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d, input logic hva);
        int n;
        pulse(a, a, d, FILT, 1'b0, 1'b1, 1'b0, hva);
        busy_len(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic en;
        int n;

        // R12: reset state
        repeat (4) @(negedge clk);
        chk("R12 busy in reset", 32'(rb_pull_low), 0);
        chk("R12 dout_en in reset", 32'(dout_en), 0);
        rst = 1'b0;
        @(negedge clk);

        // R10: clear of the whole main array
        pulse(11'd0, 11'd0, 8'h00, FILT, 1'b0, 1'b1, 1'b1, 1'b0);
        busy_len(n);
        chk("R10 clear busy length", 32'(n), 32'(NMAIN));
        for (int a = 0; a < NMAIN; a++) begin
            rd(11'(a), 1'b0, v, en);
            chk("R10 cleared byte", 32'(v), 32'hFF);
        end

        // R1 R3 R5: write every address
        for (int a = 0; a < NMAIN; a++) begin
            pulse(11'(a), 11'(a), pat(a), FILT, 1'b0, 1'b1, 1'b0, 1'b0);
            busy_len(n);
            chk("R5 write busy length", 32'(n), 32'(PC + 1));
            exp_main[a] = pat(a);
        end
        for (int a = 0; a < NMAIN; a++) begin
            rd(11'(a), 1'b0, v, en);
            chk("R1 read enable", 32'(en), 1);
            chk("R1 read data", 32'(v), 32'(exp_main[a]));
        end

        // R2: output inhibit levels
        @(negedge clk);
        cs_n = 1'b1; og_n = 1'b0; wstb_n = 1'b1; #1;
        chk("R2 standby hiz", 32'(dout_en), 0);
        cs_n = 1'b0; og_n = 1'b1; #1;
        chk("R2 og high hiz", 32'(dout_en), 0);
        og_n = 1'b0; wstb_n = 1'b0; #1;
        chk("R2 wstb low hiz", 32'(dout_en), 0);
        cs_n = 1'b1; og_n = 1'b1; wstb_n = 1'b1;

        // R6: erase before program
        wr(11'h100, 8'h0F, 1'b0);
        wr(11'h100, 8'hF0, 1'b0);
        exp_main[11'h100] = 8'hF0;
        rd(11'h100, 1'b0, v, en);
        chk("R6 overwrite", 32'(v), 32'hF0);

        // R7: data polling
        pulse(11'h123, 11'h123, 8'hA5, FILT, 1'b0, 1'b1, 1'b0, 1'b0);
        rd(11'h123, 1'b0, v, en);
        chk("R7 poll bit7 set", 32'(v), 32'h00);
        rd(11'h124, 1'b0, v, en);
        chk("R7 other addr", 32'(v), 32'(exp_main[11'h124]));
        busy_len(n);
        exp_main[11'h123] = 8'hA5;
        rd(11'h123, 1'b0, v, en);
        chk("R7 true data after", 32'(v), 32'hA5);
        pulse(11'h123, 11'h123, 8'h35, FILT, 1'b0, 1'b1, 1'b0, 1'b0);
        rd(11'h123, 1'b0, v, en);
        chk("R7 poll bit7 clear", 32'(v), 32'h80);
        busy_len(n);
        exp_main[11'h123] = 8'h35;

        // R3: location at fall, data at rise
        pulse(11'h200, 11'h201, 8'h3C, FILT, 1'b0, 1'b1, 1'b0, 1'b0);
        busy_len(n);
        exp_main[11'h200] = 8'h3C;
        rd(11'h200, 1'b0, v, en);
        chk("R3 fall address", 32'(v), 32'h3C);
        rd(11'h201, 1'b0, v, en);
        chk("R3 late address untouched", 32'(v), 32'(exp_main[11'h201]));

        // R3: inhibit by og low and by cs high
        pulse(11'h300, 11'h300, 8'h11, FILT, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 og low no busy", 32'(rb_pull_low), 0);
        pulse(11'h300, 11'h300, 8'h11, FILT, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R3 cs high no busy", 32'(rb_pull_low), 0);
        rd(11'h300, 1'b0, v, en);
        chk("R3 inhibited data", 32'(v), 32'(exp_main[11'h300]));

        // R4: filter boundary
        pulse(11'h301, 11'h301, 8'h22, FILT - 1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4 short pulse no busy", 32'(rb_pull_low), 0);
        rd(11'h301, 1'b0, v, en);
        chk("R4 short pulse data", 32'(v), 32'(exp_main[11'h301]));
        pulse(11'h301, 11'h301, 8'h22, FILT, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4 minimum pulse busy", 32'(rb_pull_low), 1);
        busy_len(n);
        exp_main[11'h301] = 8'h22;
        rd(11'h301, 1'b0, v, en);
        chk("R4 minimum pulse data", 32'(v), 32'h22);

        // R8: strobe while busy
        pulse(11'h010, 11'h010, 8'h5A, FILT, 1'b0, 1'b1, 1'b0, 1'b0);
        pulse(11'h020, 11'h020, 8'h00, FILT, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 still busy", 32'(rb_pull_low), 1);
        busy_len(n);
        chk("R8 not extended", 32'(n), 32'(PC + 1 - (FILT + 2)));
        exp_main[11'h010] = 8'h5A;
        repeat (3) @(negedge clk);
        chk("R8 no queued op", 32'(rb_pull_low), 0);
        rd(11'h020, 1'b0, v, en);
        chk("R8 ignored target", 32'(v), 32'(exp_main[11'h020]));
        rd(11'h010, 1'b0, v, en);
        chk("R8 first write", 32'(v), 32'h5A);

        // R11: supply gate
        supply_ok = 1'b0;
        pulse(11'h400, 11'h400, 8'h00, FILT, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R11 write no busy", 32'(rb_pull_low), 0);
        pulse(11'h000, 11'h000, 8'h00, FILT, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R11 clear no busy", 32'(rb_pull_low), 0);
        supply_ok = 1'b1;
        rd(11'h400, 1'b0, v, en);
        chk("R11 write blocked", 32'(v), 32'(exp_main[11'h400]));
        rd(11'h001, 1'b0, v, en);
        chk("R11 clear blocked", 32'(v), 32'(exp_main[11'h001]));

        // R9: identification row
        for (int i = 0; i < 32; i++) begin
            exp_id[i] = 8'((i * 9) + 3);
            wr(11'(11'h7E0 + i), exp_id[i], 1'b1);
        end
        for (int i = 0; i < 32; i++) begin
            rd(11'(11'h7E0 + i), 1'b1, v, en);
            chk("R9 id row read", 32'(v), 32'(exp_id[i]));
            rd(11'(11'h7E0 + i), 1'b0, v, en);
            chk("R9 main row untouched", 32'(v), 32'(exp_main[11'h7E0 + i]));
        end
        wr(11'h050, 8'h77, 1'b1);
        exp_main[11'h050] = 8'h77;
        rd(11'h050, 1'b0, v, en);
        chk("R9 flag outside window", 32'(v), 32'h77);
        pulse(11'h7E3, 11'h7E3, 8'h00, FILT, 1'b0, 1'b1, 1'b0, 1'b1);
        rd(11'h7E3, 1'b0, v, en);
        chk("R9 main not polled", 32'(v), 32'(exp_main[11'h7E3]));
        busy_len(n);
        exp_id[3] = 8'h00;

        // R12: reset keeps contents
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 busy in reset", 32'(rb_pull_low), 0);
        rst = 1'b0;
        @(negedge clk);
        rd(11'h123, 1'b0, v, en);
        chk("R12 retained", 32'(v), 32'h35);

        // R10: second clear keeps identification row
        pulse(11'h000, 11'h000, 8'h00, FILT, 1'b0, 1'b1, 1'b1, 1'b0);
        busy_len(n);
        chk("R10 clear busy length", 32'(n), 32'(NMAIN));
        for (int a = 0; a < NMAIN; a++) begin
            rd(11'(a), 1'b0, v, en);
            chk("R10 cleared byte", 32'(v), 32'hFF);
        end
        for (int i = 0; i < 32; i++) begin
            rd(11'(11'h7E0 + i), 1'b1, v, en);
            chk("R10 id row kept", 32'(v), 32'(exp_id[i]));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule